// File: doc/BRIEF.md
# Queueing Lock Controller with Per-Slot Serve Flags

This block arbitrates one shared lock among NREQ requesters and grants it strictly in ticket order. It holds a ticket counter and one serve flag per slot. When a requester asks for the lock, it takes the current ticket value as its slot number, and the counter advances by one. The requester then watches only the flag of its own slot.

Handing over the lock touches exactly two flags. The holder's flag is cleared, and the flag of the next slot is set. Slot numbers and the ticket counter both wrap modulo NREQ, so slots are reused in a cycle.

Each requester has its own acquire pulse, release pulse, latched slot number and grant output. The whole flag vector is brought out so that the hand-over can be observed. A release from a requester that does not currently hold the lock changes nothing and raises an error pulse.

Top module: `qlock_ctrl`

## Requirements
- R1: After reset the flag vector is 1 at bit 0 and 0 everywhere else, no requester holds a ticket, every grant is 0, the error output is 0, and the first ticket issued is slot 0.
- R2: An acquire pulse from a requester that holds no ticket latches the current ticket value as that requester's slot on `slot_o`, and the ticket counter advances by one at the same clock edge.
- R3: Acquires that arrive in the same cycle are numbered in ascending requester-index order, starting from the current ticket value. The counter advances by the number of tickets issued.
- R4: Exactly one flag is 1 at all times. `grant_o[i]` is 1 exactly when requester i holds a ticket and the flag at its slot is 1.
- R5: A release from the grant holder clears the flag of its slot, sets the flag of the next slot, and drops its ticket, all at one clock edge.
- R6: Both the successor slot and the ticket counter wrap modulo NREQ, so slot NREQ-1 is followed by slot 0.
- R7: The lock passes between requesters in the order in which they took their tickets.
- R8: An acquire pulse from a requester that already holds a ticket is ignored. Its slot, the ticket counter and the grants all stay the same.
- R9: A release from a requester whose grant is 0 is ignored. The flags and grants stay unchanged, and `rel_err_o` is 1 for the one cycle after the edge at which that release was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_i | input | NREQ | Per-requester acquire pulse |
| rel_i | input | NREQ | Per-requester release pulse |
| slot_o | output | NREQ*SW | Latched slot of each requester; requester i occupies bits [i*SW +: SW], with SW = clog2(NREQ) |
| grant_o | output | NREQ | Per-requester lock-held indication |
| flags_o | output | NREQ | Serve flag vector, one bit per slot |
| rel_err_o | output | 1 | One-cycle pulse after an invalid release |

## Verification
The hand-over is exercised in three ways: with one acquirer at a time, with two and four requesters acquiring in the same cycle, and with releases in both the in-order and the reversed-index sequence. Together these separate correct index-order numbering from a design that simply follows the order of the ports.

A wrap pass runs the ticket counter and the successor slot past NREQ-1. It also covers a release whose successor slot has no waiter yet, which shows that a late acquirer is granted at once.

Releases from non-holders and repeated acquires from ticket holders are placed between valid operations. This makes any disturbance they cause to the flags, slots or grants visible.

// File: rtl/qlock_ctrl.sv
module qlock_ctrl #(
  parameter int NREQ = 4,
  localparam int SW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   acq_i,
  input  logic [NREQ-1:0]   rel_i,
  output logic [NREQ*SW-1:0] slot_o,
  output logic [NREQ-1:0]   grant_o,
  output logic [NREQ-1:0]   flags_o,
  output logic              rel_err_o
);

  function automatic logic [SW-1:0] wrap_add(input logic [SW-1:0] a, input int b);
    int s;
    s = int'(a) + b;
    return SW'(s % NREQ);
  endfunction

  logic [NREQ-1:0] flags_q, flags_d, has_q, take, hold, good, bad;
  logic [SW-1:0]   slot_q [NREQ];
  logic [SW-1:0]   give   [NREQ];
  logic [SW-1:0]   next_q, next_d;
  logic            err_q;

  always_comb begin
    int k;
    k = 0;
    for (int i = 0; i < NREQ; i++) begin
      take[i] = acq_i[i] & ~has_q[i];
      give[i] = wrap_add(next_q, k);
      if (take[i]) k = k + 1;
    end
    next_d = wrap_add(next_q, k);
  end

  always_comb begin
    for (int i = 0; i < NREQ; i++)
      hold[i] = has_q[i] & flags_q[slot_q[i]];
  end

  assign good = rel_i & hold;
  assign bad  = rel_i & ~hold;

  always_comb begin
    flags_d = flags_q;
    for (int i = 0; i < NREQ; i++) begin
      if (good[i]) begin
        flags_d[slot_q[i]] = 1'b0;
        flags_d[wrap_add(slot_q[i], 1)] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= NREQ'(1);
      has_q   <= '0;
      next_q  <= '0;
      err_q   <= 1'b0;
      for (int i = 0; i < NREQ; i++) slot_q[i] <= '0;
    end else begin
      flags_q <= flags_d;
      has_q   <= (has_q & ~good) | take;
      next_q  <= next_d;
      err_q   <= |bad;
      for (int i = 0; i < NREQ; i++)
        if (take[i]) slot_q[i] <= give[i];
    end
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_slot
    assign slot_o[g*SW +: SW] = slot_q[g];
  end

  assign grant_o   = hold;
  assign flags_o   = flags_q;
  assign rel_err_o = err_q;

endmodule

// File: rtl/qlock_ctrl_chk.sv
module qlock_ctrl_chk #(
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] rel_i,
  input logic [NREQ-1:0] grant_o,
  input logic [NREQ-1:0] flags_o,
  input logic            rel_err_o
);

  // R4
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags_o) == 1);

  // R4
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R5
  handover_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(rel_i & grant_o) |=> flags_o != $past(flags_o));

  // R9
  bad_rel_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(rel_i & ~grant_o) |=> rel_err_o);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err_o |-> $past(|(rel_i & ~grant_o)));

  // R9
  bad_rel_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rel_i & ~grant_o) && !(|(rel_i & grant_o))) |=> $stable(flags_o));

endmodule

bind qlock_ctrl qlock_ctrl_chk #(.NREQ(NREQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .rel_i(rel_i),
  .grant_o(grant_o), .flags_o(flags_o), .rel_err_o(rel_err_o)
);

// File: tb/qlock_ctrl_bench.sv
module qlock_ctrl_bench;
  localparam int NREQ = 4;
  localparam int SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NREQ-1:0] acq = '0, rel = '0;
  logic [NREQ*SW-1:0] slot;
  logic [NREQ-1:0] grant, flags;
  logic err;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  qlock_ctrl #(.NREQ(NREQ)) u_qlock_ctrl (
    .clk(clk), .rst_n(rst_n), .acq_i(acq), .rel_i(rel),
    .slot_o(slot), .grant_o(grant), .flags_o(flags), .rel_err_o(err)
  );

  // {acq, rel, grant, flags, err}
  localparam logic [16:0] VEC [13] = '{
    {4'b0101, 4'b0000, 4'b0001, 4'b0001, 1'b0}, // R3 two at once
    {4'b0010, 4'b0000, 4'b0001, 4'b0001, 1'b0}, // R2
    {4'b0000, 4'b0100, 4'b0001, 4'b0001, 1'b1}, // R9 waiter releases
    {4'b0000, 4'b0001, 4'b0100, 4'b0010, 1'b0}, // R5 R7
    {4'b0001, 4'b0000, 4'b0100, 4'b0010, 1'b0}, // R2 slot 3
    {4'b0100, 4'b0000, 4'b0100, 4'b0010, 1'b0}, // R8 holder acquires
    {4'b0000, 4'b0100, 4'b0010, 4'b0100, 1'b0}, // R7
    {4'b0000, 4'b0010, 4'b0001, 4'b1000, 1'b0}, // R7
    {4'b1000, 4'b0000, 4'b0001, 4'b1000, 1'b0}, // R6 ticket wraps
    {4'b0000, 4'b0001, 4'b1000, 4'b0001, 1'b0}, // R6 successor wraps
    {4'b0000, 4'b1000, 4'b0000, 4'b0010, 1'b0}, // R5 no waiter
    {4'b0010, 4'b0000, 4'b0010, 4'b0010, 1'b0}, // R4 late acquirer
    {4'b0000, 4'b0010, 4'b0000, 4'b0100, 1'b0}  // R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [NREQ-1:0] a, input logic [NREQ-1:0] r);
    acq = a;
    rel = r;
    @(posedge clk);
    #2;
    acq = '0;
    rel = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1'b1;
  endtask

  function automatic logic [SW-1:0] slot_of(input int i);
    return slot[i*SW +: SW];
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 flags", 32'(flags), 32'b0001);
    chk("R1 grant", 32'(grant), 32'b0000);
    chk("R1 err", 32'(err), 32'd0);

    for (int v = 0; v < 13; v++) begin
      step(VEC[v][16:13], VEC[v][12:9]);
      chk($sformatf("vec%0d grant", v), 32'(grant), 32'(VEC[v][8:5]));
      chk($sformatf("vec%0d flags", v), 32'(flags), 32'(VEC[v][4:1]));
      chk($sformatf("vec%0d err", v), 32'(err), 32'(VEC[v][0]));
    end

    // R1 first ticket is slot 0; R3 four simultaneous in index order
    do_reset();
    step(4'b1111, 4'b0000);
    for (int i = 0; i < NREQ; i++)
      chk($sformatf("R3 slot req%0d", i), 32'(slot_of(i)), 32'(i));
    chk("R4 grant first", 32'(grant), 32'b0001);

    // R8 repeated acquire keeps slots
    step(4'b1111, 4'b0000);
    for (int i = 0; i < NREQ; i++)
      chk($sformatf("R8 slot req%0d", i), 32'(slot_of(i)), 32'(i));

    // R9 release by waiter in reversed order leaves state
    step(4'b0000, 4'b1000);
    chk("R9 err", 32'(err), 32'd1);
    chk("R9 grant", 32'(grant), 32'b0001);

    // R7 FIFO hand-over
    step(4'b0000, 4'b0001);
    chk("R7 to req1", 32'(grant), 32'b0010);
    step(4'b0000, 4'b0010);
    chk("R7 to req2", 32'(grant), 32'b0100);
    step(4'b0000, 4'b0100);
    chk("R7 to req3", 32'(grant), 32'b1000);
    step(4'b0000, 4'b1000);
    chk("R6 flags wrap", 32'(flags), 32'b0001);
    chk("R5 no holder", 32'(grant), 32'b0000);

    // R6 ticket counter wrapped to 0
    step(4'b0100, 4'b0000);
    chk("R6 ticket wrap", 32'(slot_of(2)), 32'd0);
    chk("R2 immediate grant", 32'(grant), 32'b0100);
    step(4'b0001, 4'b0000);
    chk("R2 next slot", 32'(slot_of(0)), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule